// File: doc/BRIEF.md
# Serial Display Command/Pixel Transmitter

This block is a transmit-only serial master for a display panel. A client presents a parallel word together with a command/data flag and hands it over through a valid/ready handshake. The block then lowers chip select and clocks the frame out on a single data line. When the flag bit is enabled, the frame opens with the command/data flag. The payload follows, most significant bit first, and its length is 8, 16, 18 or 24 bits.

Clock polarity, clock phase, payload length and flag enable are inputs. They are captured at the moment a word is accepted and hold for the whole frame. Each half-period of the serial clock is paced either by an external timer tick, in which case the clock period is two ticks, or by the system clock directly when fast mode is selected. A one-cycle done pulse marks the end of every frame.

Top module: `lcd_serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, chip select is high, busy is low, ready is high, done is low, and the serial clock sits at the idle level set by the polarity input (0 gives an idle-low clock, 1 gives an idle-high clock). The data line resets to 0.
- R2: A word is accepted on a clock edge where valid and ready are both high. Ready equals not busy. A valid word offered while busy is ignored, and the frame in progress is unaffected.
- R3: A frame produces exactly 2 × L serial clock edges. L is the payload width, plus 1 when the flag bit is enabled.
- R4: Mode encoding for the payload width: 0 gives 8 bits, 1 gives 16, 2 gives 18 and 3 gives 24. Only the low L payload bits of the input word are sent. Higher bits are ignored.
- R5: When the flag enable is 1, the command/data flag is the first bit of the frame. When it is 0, no flag bit is sent.
- R6: The payload is sent most significant bit first and ends with bit 0.
- R7: The first (leading) edge of every clock cycle moves the clock away from its idle level.
- R8: With phase 0, each bit is on the data line before the leading edge and changes only on trailing edges. With phase 1, each bit changes on a leading edge and is stable at the following trailing edge.
- R9: Chip select falls on the accepting edge. The first clock edge comes on the next step. Chip select rises on the step after the last edge. In fast mode, a step is one system clock.
- R10: In tick mode, the serial clock changes only on a system clock edge where the tick input was high. In fast mode, the tick input has no effect on timing.
- R11: Polarity, phase, payload mode, flag enable and clock mode are captured on acceptance. Changes to them during a frame do not alter that frame.
- R12: Done is high for exactly one system clock, in the cycle in which chip select has just risen. The data line holds its last value between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | External timer tick; one half-period per tick in tick mode |
| fast_i | input | 1 | 1 selects system-clock pacing, 0 selects tick pacing |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Serial clock phase |
| cmd_en_i | input | 1 | Enables the leading command/data flag bit |
| dmode_i | input | 2 | Payload width select |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | DATA_W | Payload word, right aligned |
| in_cmd | input | 1 | Command/data flag value |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Chip select, active low |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
Several properties are checked on every cycle by the assertions. The done pulse must coincide with chip select rising. The captured settings must stay frozen while a frame runs. In tick mode the clock must not move without a tick. The data line must hold still between frames, and the half-period counter must stay in range. Other behaviour can only be shown by the bench's scenarios. These cover the bit order and the exact frame content for every width and flag setting. They also cover phase-dependent sampling, the edge count, the chip select lead and lag in fast mode, and the rejection of words offered while busy. The bench decodes the data line at the sampling edge implied by phase and polarity and compares the result with a frame it builds itself.

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              fast_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              cmd_en_i,
  input  logic [1:0]        dmode_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cmd,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              cs_n_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FW = DATA_W + 1;
  localparam int CW = $clog2(2 * FW + 1);

  function automatic int pay_len(input logic [1:0] m);
    case (m)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 18;
      default: return 24;
    endcase
  endfunction

  logic [1:0]    mode_q;
  logic          cpol_q, cpha_q, cmden_q, fast_q;
  logic [FW-1:0] sr;
  logic [CW-1:0] hcnt, nedge;
  logic          tog, cs_n, done_q, sdo_q;

  logic [DATA_W-1:0] pay;
  logic [FW-1:0]     fr;
  logic [CW-1:0]     flen;

  assign pay  = in_data << (DATA_W - pay_len(dmode_i));
  assign fr   = cmd_en_i ? {in_cmd, pay} : {pay, 1'b0};
  assign flen = CW'(pay_len(dmode_i)) + CW'(cmd_en_i);

  wire accept    = in_valid && cs_n;
  wire step      = fast_q || tick_i;
  wire shift_now = cpha_q ? !hcnt[0] : (hcnt[0] && (hcnt + 1'b1 != nedge));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= 1'b1; done_q <= 1'b0; sdo_q <= 1'b0; tog <= 1'b0;
      hcnt <= '0; nedge <= '0; sr <= '0; mode_q <= '0;
      cpol_q <= 1'b0; cpha_q <= 1'b0; cmden_q <= 1'b0; fast_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cs_n    <= 1'b0;
        hcnt    <= '0;
        tog     <= 1'b0;
        nedge   <= flen << 1;
        mode_q  <= dmode_i;
        cpol_q  <= cpol_i;
        cpha_q  <= cpha_i;
        cmden_q <= cmd_en_i;
        fast_q  <= fast_i;
        if (!cpha_i) begin
          sdo_q <= fr[FW-1];
          sr    <= fr << 1;
        end else begin
          sr    <= fr;
        end
      end else if (!cs_n && step) begin
        if (hcnt == nedge) begin
          cs_n   <= 1'b1;
          done_q <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
          tog  <= ~tog;
          if (shift_now) begin
            sdo_q <= sr[FW-1];
            sr    <= sr << 1;
          end
        end
      end
    end
  end

  assign in_ready = cs_n;
  assign busy_o   = !cs_n;
  assign cs_n_o   = cs_n;
  assign done_o   = done_q;
  assign sdo_o    = sdo_q;
  assign sclk_o   = cs_n ? cpol_i : (cpol_q ^ tog);

  assert_done_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && $past(!cs_n_o)));

  assert_sdo_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o)) |-> $stable(sdo_o));

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o)) |->
      ($stable(mode_q) && $stable(cpol_q) && $stable(cpha_q) && $stable(cmden_q) && $stable(fast_q)));

  assert_no_tick_no_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o) && !fast_q && !$past(tick_i)) |-> $stable(sclk_o));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> (hcnt <= nedge));

  assert_busy_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy_o) |=> !done_o || $past(hcnt == nedge));
endmodule

// File: tb/sim_lcd_serial_tx.sv
module sim_lcd_serial_tx;
  logic clk = 0, rst_n = 0;
  logic tick_i = 0, fast_i = 1, cpol_i = 0, cpha_i = 0, cmd_en_i = 0;
  logic [1:0] dmode_i = 0;
  logic in_valid = 0, in_cmd = 0;
  logic [23:0] in_data = 0;
  logic in_ready, sclk_o, sdo_o, cs_n_o, busy_o, done_o;

  always #4 clk = ~clk;

  lcd_serial_tx #(.DATA_W(24)) u0 (.*);

  int checks = 0, errors = 0;
  bit tmode = 0;
  int tcnt = 0;

  always @(posedge clk) begin
    tcnt   <= (tcnt == 2) ? 0 : tcnt + 1;
    tick_i <= tmode ? (tcnt == 2) : 1'($urandom % 2);
  end

  task automatic chk(bit ok, string r, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int plen(logic [1:0] m);
    return (m == 0) ? 8 : (m == 1) ? 16 : (m == 2) ? 18 : 24;
  endfunction

  function automatic logic [31:0] build(logic [23:0] d, logic c, logic [1:0] m, logic ce);
    logic [31:0] p = 32'(d) & ((32'd1 << plen(m)) - 1);
    return ce ? (p | (32'(c) << plen(m))) : p;
  endfunction

  logic [31:0] exp_fr;
  int exp_len = 0;
  logic exp_cpol = 0, exp_cpha = 0, exp_fast = 1;
  int frames_done = 0;

  logic prev_sclk = 0, prev_cs = 1, tick_prev = 0;
  logic [31:0] cap;
  int ecnt, cyc, since;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n_o) begin
        if (prev_cs) begin
          ecnt = 0; cyc = 0; since = 0; cap = 0;
          chk(sclk_o == exp_cpol, "R7 idle level at frame start", sclk_o, exp_cpol);
        end else begin
          cyc++;
          chk(!in_ready, "R2 ready low while busy", in_ready, 0);
          if (sclk_o != prev_sclk) begin
            if (!exp_fast) chk(tick_prev, "R10 edge without tick", 0, 1);
            if (ecnt == 0 && exp_fast) chk(cyc == 1, "R9 lead one half period", cyc, 1);
            ecnt++;
            since = 0;
            if ((ecnt % 2 == 1) != exp_cpha) cap = {cap[30:0], sdo_o};
          end else since++;
        end
      end else if (!prev_cs) begin
        frames_done++;
        chk(done_o, "R12 done with cs rise", done_o, 1);
        chk(ecnt == 2 * exp_len, "R3 edge count", ecnt, 2 * exp_len);
        chk((cap & ((32'd1 << exp_len) - 1)) == exp_fr, "R4 R5 R6 R8 frame bits",
            cap & ((32'd1 << exp_len) - 1), exp_fr);
        if (exp_fast) chk(since == 0, "R9 lag one half period", since + 1, 1);
        chk(sclk_o == cpol_i, "R1 idle clock level", sclk_o, cpol_i);
      end else begin
        chk(!done_o, "R12 done only one cycle", done_o, 0);
        chk(sclk_o == cpol_i, "R1 idle clock between frames", sclk_o, cpol_i);
      end
    end
    prev_sclk = sclk_o;
    prev_cs   = cs_n_o;
    tick_prev = tick_i;
  end

  task automatic send(logic [23:0] d, logic c, logic [1:0] m, logic ce,
                      logic po, logic ph, logic fm);
    logic last_sdo;
    @(negedge clk);
    fast_i = fm; cpol_i = po; cpha_i = ph; cmd_en_i = ce; dmode_i = m;
    in_data = d; in_cmd = c; in_valid = 1;
    while (!in_ready) @(negedge clk);
    exp_fr = build(d, c, m, ce); exp_len = plen(m) + int'(ce);
    exp_cpol = po; exp_cpha = ph; exp_fast = fm;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      in_data = 24'($urandom); in_cmd = 1'($urandom);
      cpha_i = 1'($urandom); dmode_i = 2'($urandom); cmd_en_i = 1'($urandom);
      @(negedge clk);
    end
    in_valid = 0;
    cpol_i = po;
    while (!done_o) @(negedge clk);
    last_sdo = sdo_o;
    repeat (3) @(negedge clk);
    chk(sdo_o == last_sdo, "R12 data line held between frames", sdo_o, last_sdo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n_o && in_ready && !busy_o && !done_o, "R1 reset handshake state",
        {cs_n_o, in_ready, busy_o, done_o}, 4'b1100);
    chk(sclk_o == 0 && sdo_o == 0, "R1 reset clock and data", {sclk_o, sdo_o}, 0);
    rst_n = 1;
    @(negedge clk);
    cpol_i = 1;
    @(negedge clk);
    chk(sclk_o == 1, "R1 idle high with polarity 1", sclk_o, 1);
    cpol_i = 0;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++)
        send(24'hFFFFFF ^ (24'h5A5A5A << m), k[0], 2'(m), k[1], k[2], 1'(k >> 2 ^ k), 1);
    send(24'h000001, 1, 2, 1, 0, 0, 1);
    send(24'h800000, 0, 3, 0, 1, 1, 1);
    tmode = 1;
    for (int i = 0; i < 16; i++)
      send(24'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 0);
    tmode = 0;
    for (int i = 0; i < 40; i++)
      send(24'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1);
    n = 32 + 2 + 16 + 40;
    chk(frames_done == n, "R2 one frame per accepted word", frames_done, n);
    finish_run();
  end
endmodule